// File: doc/BRIEF.md
# Software Flow Control with Any-Character Resume

This block sits between a UART receiver and its transmitter and carries out in-band software flow control. Each received character arrives with a one-cycle valid strobe. The block compares it with two programmable characters: one that stops the transmitter and one that restarts it. The block holds a two-state machine that records whether the transmitter may start a new character. For every received character it also decides whether the character is written into the receive FIFO. Serial framing, the FIFO storage and sending flow-control characters outward are handled elsewhere.

An optional any-character resume mode lets any received character restart a halted transmitter. In that mode ordinary characters are still stored. While flow control is enabled, the stop and restart characters themselves never reach the FIFO. The resume-mode enable is a configuration bit that resets to off. A write to it takes effect only while the enhanced-features input is high.

The state machine has two states, `ST_RUN` and `ST_HALTED`. It has these transitions:
- RUN to HALTED on a received stop character with flow control enabled.
- HALTED to RUN on a received restart character.
- HALTED to RUN on any other received character while resume mode is on.
- HALTED to RUN whenever flow control is disabled.

A character that matches both programmed characters counts as a stop character.

Top module: `swfc_xon_any`

## Requirements
- R1: After reset `tx_allow` is 1, `fifo_wr` is 0 and any-character resume is disabled.
- R2: With `fc_en` = 1, a valid character equal to `xoff_char` drives `tx_allow` to 0 from the next cycle. This holds even when it also equals `xon_char`.
- R3: With `fc_en` = 1, a valid character equal to `xon_char` (and not `xoff_char`) drives `tx_allow` to 1 from the next cycle, whatever the resume mode.
- R4: With resume mode on and the transmitter halted, any valid character other than the stop character sets `tx_allow` to 1 in the next cycle.
- R5: With resume mode off and the transmitter halted, a valid character that matches neither programmed character leaves `tx_allow` at 0.
- R6: A valid character that is not filtered produces a one-cycle `fifo_wr` pulse in the next cycle, with `fifo_wdata` equal to that character.
- R7: With `fc_en` = 1, a valid character equal to `xon_char` or `xoff_char` produces no `fifo_wr`. This holds in resume mode as well.
- R8: With `fc_en` = 0, every valid character is written to the FIFO. `tx_allow` is 1 from the cycle after `fc_en` is low.
- R9: The resume-mode bit loads `any_wdata` on `any_wr` only when `enh_en` = 1. Otherwise the write is ignored.
- R10: `tx_start` equals `tx_req` AND `tx_allow` in the same cycle. A start granted in the cycle that the stop character arrives is kept, and blocking applies only to later starts.
- R11: With `rx_valid` = 0, `rx_data` has no effect on `fifo_wr` or `tx_allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_data` |
| xon_char | input | 8 | Restart character |
| xoff_char | input | 8 | Stop character |
| fc_en | input | 1 | Software flow control enable |
| enh_en | input | 1 | Enhanced-features gate for the resume-mode bit |
| any_wr | input | 1 | Write strobe for the resume-mode bit |
| any_wdata | input | 1 | Value written to the resume-mode bit |
| tx_req | input | 1 | Transmitter wants to start a new character |
| tx_allow | output | 1 | Transmitter may start new characters |
| tx_start | output | 1 | Grant to start a character this cycle |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Character to write into the receive FIFO |

## Verification
The resume-mode bit has no output of its own, so it can only be seen through the transmitter state. To check that a write is ignored, the bench first halts the transmitter with a stop character. It then attempts the write with `enh_en` low and sends an ordinary character. A write that wrongly took effect would show up as `tx_allow` rising. The same halted setup is reused after a reset to show that the bit clears to off. The grant-versus-halt timing is checked by raising `tx_req` in the very cycle the stop character arrives, and sampling `tx_start` both before and after that clock edge.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } fc_state_e;

    typedef struct packed {
        logic hit_xon;
        logic hit_xoff;
    } match_t;
endpackage

// File: rtl/swfc_char_match.sv
module swfc_char_match
    import swfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] xon_char,
    input  logic [DATA_W-1:0] xoff_char,
    input  logic              fc_en,
    output match_t            hits
);
    // Hits only count while flow control is enabled.
    always_comb begin
        hits.hit_xon  = fc_en && (rx_data == xon_char);
        hits.hit_xoff = fc_en && (rx_data == xoff_char);
    end
endmodule

// File: rtl/swfc_resume_cfg.sv
module swfc_resume_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic enh_en,
    input  logic any_wr,
    input  logic any_wdata,
    output logic any_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any_en <= 1'b0;
        end else if (any_wr && enh_en) begin
            any_en <= any_wdata;
        end
    end

    // R9
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |=> $stable(any_en));
endmodule

// File: rtl/swfc_rx_gate.sv
module swfc_rx_gate
    import swfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  match_t            hits,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata
);
    logic store_now;

    always_comb begin
        store_now = rx_valid && !(hits.hit_xon || hits.hit_xoff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_wr <= store_now;
            if (store_now) begin
                fifo_wdata <= rx_data;
            end
        end
    end

    // R11
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(rx_valid));
endmodule

// File: rtl/swfc_fsm.sv
module swfc_fsm
    import swfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rx_valid,
    input  match_t hits,
    input  logic   fc_en,
    input  logic   any_en,
    output logic   tx_allow
);
    fc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (rx_valid && hits.hit_xoff) begin
                    state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                if (!fc_en) begin
                    state_d = ST_RUN;
                end else if (rx_valid && !hits.hit_xoff) begin
                    if (hits.hit_xon || any_en) begin
                        state_d = ST_RUN;
                    end
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        tx_allow = (state_q == ST_RUN);
    end

    // R2
    xoff_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && hits.hit_xoff) |=> !tx_allow);
    // R8
    disabled_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> tx_allow);
    // R3
    xon_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && hits.hit_xon && !hits.hit_xoff) |=> tx_allow);
endmodule

// File: rtl/swfc_xon_any.sv
module swfc_xon_any
    import swfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    input  logic [7:0] xon_char,
    input  logic [7:0] xoff_char,
    input  logic       fc_en,
    input  logic       enh_en,
    input  logic       any_wr,
    input  logic       any_wdata,
    input  logic       tx_req,
    output logic       tx_allow,
    output logic       tx_start,
    output logic       fifo_wr,
    output logic [7:0] fifo_wdata
);
    localparam int DATA_W = 8;

    match_t hits;
    logic   any_en;

    swfc_char_match #(.DATA_W(DATA_W)) u_match (
        .rx_data   (rx_data),
        .xon_char  (xon_char),
        .xoff_char (xoff_char),
        .fc_en     (fc_en),
        .hits      (hits)
    );

    swfc_resume_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enh_en    (enh_en),
        .any_wr    (any_wr),
        .any_wdata (any_wdata),
        .any_en    (any_en)
    );

    swfc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .hits     (hits),
        .fc_en    (fc_en),
        .any_en   (any_en),
        .tx_allow (tx_allow)
    );

    swfc_rx_gate #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .hits       (hits),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata)
    );

    always_comb begin
        tx_start = tx_req && tx_allow;
    end

    // R7
    flow_char_filtered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_en && ((rx_data == xon_char) || (rx_data == xoff_char)))
        |=> !fifo_wr);
    // R10
    no_start_after_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_en && (rx_data == xoff_char)) |=> !tx_start);
    // R6
    plain_char_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !(fc_en && ((rx_data == xon_char) || (rx_data == xoff_char))))
        |=> (fifo_wr && fifo_wdata == $past(rx_data)));
endmodule

// File: tb/swfc_xon_any_tb.sv
module swfc_xon_any_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] xon_char = 8'h11;
    logic [7:0] xoff_char = 8'h13;
    logic       fc_en = 1'b1;
    logic       enh_en = 1'b0;
    logic       any_wr = 1'b0;
    logic       any_wdata = 1'b0;
    logic       tx_req = 1'b0;
    logic       tx_allow, tx_start, fifo_wr;
    logic [7:0] fifo_wdata;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    swfc_xon_any u_dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .xon_char(xon_char), .xoff_char(xoff_char), .fc_en(fc_en),
        .enh_en(enh_en), .any_wr(any_wr), .any_wdata(any_wdata),
        .tx_req(tx_req), .tx_allow(tx_allow), .tx_start(tx_start),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
    );

    // entry: {fc_en, rx_valid, rx_data[7:0], exp_fifo_wr, exp_tx_allow}
    localparam logic [11:0] VEC [10] = '{
        {1'b1, 1'b1, 8'h41, 1'b1, 1'b1},  // R6 plain stored
        {1'b1, 1'b1, 8'h13, 1'b0, 1'b0},  // R2 R7 xoff halts, filtered
        {1'b1, 1'b1, 8'h42, 1'b1, 1'b0},  // R5 plain does not resume
        {1'b1, 1'b0, 8'h11, 1'b0, 1'b0},  // R11 no valid ignored
        {1'b1, 1'b1, 8'h11, 1'b0, 1'b1},  // R3 xon resumes, filtered
        {1'b1, 1'b1, 8'h11, 1'b0, 1'b1},  // R3 xon while running
        {1'b0, 1'b1, 8'h13, 1'b1, 1'b1},  // R8 disabled: stored
        {1'b0, 1'b1, 8'h11, 1'b1, 1'b1},  // R8
        {1'b1, 1'b1, 8'h13, 1'b0, 1'b0},  // R2
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b1}   // R8 disable releases
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_cycle(input logic fc, input logic v, input logic [7:0] d);
        fc_en = fc;
        rx_valid = v;
        rx_data = d;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic write_any(input logic enh, input logic val);
        enh_en = enh;
        any_wr = 1'b1;
        any_wdata = val;
        @(posedge clk);
        @(negedge clk);
        any_wr = 1'b0;
        enh_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk({7'd0, tx_allow}, 8'h01, "R1 tx_allow");
        chk({7'd0, fifo_wr}, 8'h00, "R1 fifo_wr");

        for (int i = 0; i < 10; i++) begin
            rx_cycle(VEC[i][11], VEC[i][10], VEC[i][9:2]);
            chk({7'd0, fifo_wr}, {7'd0, VEC[i][1]}, "R6/R7/R8/R11 fifo_wr");
            if (VEC[i][1]) chk(fifo_wdata, VEC[i][9:2], "R6 fifo_wdata");
            chk({7'd0, tx_allow}, {7'd0, VEC[i][0]}, "R2/R3/R5/R8 tx_allow");
        end

        // R10: start granted in the cycle of the stop char, blocked after
        tx_req = 1'b1;
        fc_en = 1'b1;
        rx_valid = 1'b1;
        rx_data = 8'h13;
        #1;
        chk({7'd0, tx_start}, 8'h01, "R10 grant in xoff cycle");
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        chk({7'd0, tx_start}, 8'h00, "R10 blocked after xoff");
        tx_req = 1'b0;

        // R9: write ignored without enh_en (still halted)
        write_any(1'b0, 1'b1);
        rx_cycle(1'b1, 1'b1, 8'h41);
        chk({7'd0, tx_allow}, 8'h00, "R9 write ignored");
        chk({7'd0, fifo_wr}, 8'h01, "R6 stored while halted");

        // R9 + R4: write with enh_en, plain char resumes and is stored
        write_any(1'b1, 1'b1);
        chk({7'd0, tx_allow}, 8'h00, "R4 still halted before char");
        rx_cycle(1'b1, 1'b1, 8'h42);
        chk({7'd0, tx_allow}, 8'h01, "R4 any char resumes");
        chk(fifo_wdata, 8'h42, "R4 resume char stored");

        // R7 in resume mode: xoff halts and is filtered, xon resumes filtered
        rx_cycle(1'b1, 1'b1, 8'h13);
        chk({7'd0, tx_allow}, 8'h00, "R2 xoff in resume mode");
        chk({7'd0, fifo_wr}, 8'h00, "R7 xoff filtered in resume mode");
        rx_cycle(1'b1, 1'b1, 8'h11);
        chk({7'd0, tx_allow}, 8'h01, "R3 xon in resume mode");
        chk({7'd0, fifo_wr}, 8'h00, "R7 xon filtered in resume mode");

        // R2: stop and restart characters identical -> treated as stop
        xon_char = 8'h55;
        xoff_char = 8'h55;
        rx_cycle(1'b1, 1'b1, 8'h55);
        chk({7'd0, tx_allow}, 8'h00, "R2 xoff wins on double match");
        xon_char = 8'h11;
        xoff_char = 8'h13;

        // R1: reset clears resume mode
        do_reset();
        chk({7'd0, tx_allow}, 8'h01, "R1 tx_allow after second reset");
        rx_cycle(1'b1, 1'b1, 8'h13);
        rx_cycle(1'b1, 1'b1, 8'h41);
        chk({7'd0, tx_allow}, 8'h00, "R1 resume mode off after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule